// File: doc/BRIEF.md
# Indicator and Stop-Output Controller

This block turns two small control registers into the indicator and stop-signal pins of a voice playback device. A stop register sets three stop lines. A stop line is driven low while its register bit is set. A mode register selects steady or flashing indicator LEDs. It also decides the role of a shared pin: a trigger input, the second LED output, or the third stop line.

The flash runs from a slow tick input. The phase of the flash toggles after a fixed number of ticks, and that count is chosen so the LEDs blink at about 3 Hz. A static parameter sets how the two LEDs flash: both in phase, or in antiphase. The playback engine supplies a per-section LED flag. Both LEDs stay dark while this flag is low. Each time the flag rises, the flash restarts in its lit phase.

Top module: `ind_stop_ctrl`

## Requirements
- R1: Stop register bit 0 drives `stop_a_n`, bit 1 drives `stop_b_n` and bit 2 drives the stop role of the shared pin. Stop register bits 7 to 3 have no effect on any output.
- R2: Every stop output is low while its register bit is 1 and high while the bit is 0.
- R3: While `rst` is high, the stop register is loaded with 3'b111 and the mode bits 7 to 5 with 3'b111. The outputs are then: `led1`=0, `stop_a_n`=0, `stop_b_n`=0, `pin4_oe`=0 and `pin4_out`=0.
- R4: A value written with `stop_wr` or `mode_wr` at clock edge k first shows on the outputs after clock edge k+1.
- R5: `led1`, and the LED role of the shared pin, are low after edge k whenever `sect_led` was low at edge k.
- R6: When mode bit 7 is 0, the LEDs are steadily on while `sect_led` is high. This holds for both flash options.
- R7: When mode bit 7 is 1, the flash phase inverts once every HALF_TICKS tick pulses. With the tick rate set to 6*HALF_TICKS per second, the flash runs at 3 Hz.
- R8: While `sect_led` is low, the tick count is cleared and the phase is held lit. The first LED output after `sect_led` rises is therefore on.
- R9: With ALT_FLASH=0, the LED role of the shared pin always equals `led1`.
- R10: With ALT_FLASH=1 and flashing selected, the LED role of the shared pin is the inverse of `led1` while `sect_led` is high.
- R11: Mode bit 5 = 1 makes the shared pin a trigger input: `pin4_oe`=0 and `pin4_out`=0.
- R12: Mode bit 5 = 0 drives the shared pin (`pin4_oe`=1). Mode bit 6 = 1 gives it the LED2 value. Mode bit 6 = 0 gives it the active-low stop value of stop register bit 2.
- R13: Mode bits 4 to 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_wr | input | 1 | Load strobe for the stop register |
| stop_din | input | 8 | Stop register write data |
| mode_wr | input | 1 | Load strobe for the mode register |
| mode_din | input | 8 | Mode register write data |
| tick | input | 1 | One-cycle flash timebase pulse |
| sect_led | input | 1 | LED flag of the section now playing |
| led1 | output | 1 | First indicator LED, active high |
| stop_a_n | output | 1 | First stop line, active low |
| stop_b_n | output | 1 | Second stop line, active low |
| pin4_out | output | 1 | Output value of the shared pin |
| pin4_oe | output | 1 | Output enable of the shared pin |

## Verification
A register write sampled at edge k reaches the pins only after edge k+1, because the register and the output stage each add one edge. The section flag and the tick each reach the LED outputs one edge after they are sampled. The flash phase, in turn, changes at the edge that receives the closing tick and shows at the following edge. The bench drives inputs and compares outputs on falling edges. Its behavioural model steps once on each rising edge, so every comparison lands exactly where these latencies put the new value. Directed checks in the bench wait the same number of edges, once to see the old value and once more to see the new one.

// File: rtl/ind_pkg.sv
package ind_pkg;

  localparam int NSTOP = 3;

  // upper mode bits that this block decodes
  typedef struct packed {
    logic flash;     // bit 7: 1 flash, 0 steady
    logic p4_led;    // bit 6: 1 LED2, 0 third stop line
    logic p4_trig;   // bit 5: 1 shared pin is a trigger input
  } mode_t;

  typedef enum logic [1:0] {
    P4_TRIG = 2'd0,
    P4_LED  = 2'd1,
    P4_STOP = 2'd2
  } p4_role_t;

  localparam logic [NSTOP-1:0] STOP_RST = '1;
  localparam mode_t            MODE_RST = '{flash: 1'b1, p4_led: 1'b1, p4_trig: 1'b1};

endpackage

// File: rtl/ind_regs.sv
module ind_regs
  import ind_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_wr,
  input  logic [NSTOP-1:0] stop_bits,
  input  logic             mode_wr,
  input  mode_t            mode_bits,
  output logic [NSTOP-1:0] stop_q,
  output mode_t            mode_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q <= STOP_RST;
      mode_q <= MODE_RST;
    end else begin
      if (stop_wr) stop_q <= stop_bits;
      if (mode_wr) mode_q <= mode_bits;
    end
  end

endmodule

// File: rtl/ind_flash.sv
module ind_flash #(
  parameter int HALF_TICKS = 167
) (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic tick,
  output logic phase_o
);

  localparam int            CW   = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

  logic [CW-1:0] cnt_q;

  // the phase restarts lit whenever the section flag is low
  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      cnt_q   <= '0;
      phase_o <= 1'b1;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        phase_o <= ~phase_o;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ind_pinmux.sv
module ind_pinmux
  import ind_pkg::*;
#(
  parameter bit ALT_FLASH = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sect,
  input  logic             phase,
  input  logic [NSTOP-1:0] stop_q,
  input  mode_t            mode_q,
  output logic             led1_q,
  output logic [NSTOP-2:0] stop_n_q,
  output logic             p4_out_q,
  output logic             p4_oe_q
);

  logic     led1_c;
  logic     led2_c;
  p4_role_t role;

  assign led1_c = sect & (mode_q.flash ? phase : 1'b1);

  generate
    if (ALT_FLASH) begin : g_alt
      assign led2_c = sect & (mode_q.flash ? ~phase : 1'b1);
    end else begin : g_sync
      assign led2_c = led1_c;
    end
  endgenerate

  always_comb begin
    if (mode_q.p4_trig)     role = P4_TRIG;
    else if (mode_q.p4_led) role = P4_LED;
    else                    role = P4_STOP;
  end

  // dedicated stop lines, one register each
  generate
    for (genvar g = 0; g < NSTOP-1; g++) begin : g_stop
      always_ff @(posedge clk) begin
        if (rst) stop_n_q[g] <= ~STOP_RST[g];
        else     stop_n_q[g] <= ~stop_q[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      led1_q   <= 1'b0;
      p4_out_q <= 1'b0;
      p4_oe_q  <= 1'b0;
    end else begin
      led1_q <= led1_c;
      unique case (role)
        P4_LED: begin
          p4_out_q <= led2_c;
          p4_oe_q  <= 1'b1;
        end
        P4_STOP: begin
          p4_out_q <= ~stop_q[NSTOP-1];
          p4_oe_q  <= 1'b1;
        end
        default: begin
          p4_out_q <= 1'b0;
          p4_oe_q  <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ind_stop_ctrl.sv
module ind_stop_ctrl
  import ind_pkg::*;
#(
  parameter int HALF_TICKS = 167,
  parameter bit ALT_FLASH  = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stop_wr,
  input  logic [7:0] stop_din,
  input  logic       mode_wr,
  input  logic [7:0] mode_din,
  input  logic       tick,
  input  logic       sect_led,
  output logic       led1,
  output logic       stop_a_n,
  output logic       stop_b_n,
  output logic       pin4_out,
  output logic       pin4_oe
);

  logic [NSTOP-1:0] stop_q;
  mode_t            mode_q;
  mode_t            mode_w;
  logic             phase;
  logic [NSTOP-2:0] stop_n;
  logic             unused_bits;

  assign mode_w      = mode_t'(mode_din[7:5]);
  assign unused_bits = ^{stop_din[7:NSTOP], mode_din[4:0]};

  ind_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .stop_wr   (stop_wr),
    .stop_bits (stop_din[NSTOP-1:0]),
    .mode_wr   (mode_wr),
    .mode_bits (mode_w),
    .stop_q    (stop_q),
    .mode_q    (mode_q)
  );

  ind_flash #(.HALF_TICKS(HALF_TICKS)) u_flash (
    .clk     (clk),
    .rst     (rst),
    .enable  (sect_led),
    .tick    (tick),
    .phase_o (phase)
  );

  ind_pinmux #(.ALT_FLASH(ALT_FLASH)) u_mux (
    .clk      (clk),
    .rst      (rst),
    .sect     (sect_led),
    .phase    (phase),
    .stop_q   (stop_q),
    .mode_q   (mode_q),
    .led1_q   (led1),
    .stop_n_q (stop_n),
    .p4_out_q (pin4_out),
    .p4_oe_q  (pin4_oe)
  );

  assign stop_a_n = stop_n[0];
  assign stop_b_n = stop_n[1];

endmodule

// File: rtl/ind_stop_ctrl_chk.sv
module ind_stop_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       stop_wr,
  input logic [7:0] stop_din,
  input logic       mode_wr,
  input logic [7:0] mode_din,
  input logic       sect_led,
  input logic       led1,
  input logic       stop_a_n,
  input logic       stop_b_n,
  input logic       pin4_out,
  input logic       pin4_oe
);

  // R3
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!led1 && !stop_a_n && !stop_b_n && !pin4_oe && !pin4_out));

  // R2
  stop_level_chk: assert property (@(posedge clk) disable iff (rst)
    stop_wr |=> ##1 (stop_a_n == !$past(stop_din[0], 2) && stop_b_n == !$past(stop_din[1], 2)));

  // R11
  trig_release_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_wr && mode_din[5]) |=> ##1 (!pin4_oe && !pin4_out));

  // R5
  dark_section_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sect_led) |-> !led1);

  // R8
  lit_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sect_led) |=> led1);

endmodule

bind ind_stop_ctrl ind_stop_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .stop_wr  (stop_wr),
  .stop_din (stop_din),
  .mode_wr  (mode_wr),
  .mode_din (mode_din),
  .sect_led (sect_led),
  .led1     (led1),
  .stop_a_n (stop_a_n),
  .stop_b_n (stop_b_n),
  .pin4_out (pin4_out),
  .pin4_oe  (pin4_oe)
);

// File: tb/test_ind_stop_ctrl.sv
`timescale 1ns/1ps
module test_ind_stop_ctrl;

  localparam int HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_wr = 1'b0;
  logic [7:0] stop_din = 8'h00;
  logic       mode_wr = 1'b0;
  logic [7:0] mode_din = 8'h00;
  logic       tick = 1'b0;
  logic       sect_led = 1'b0;

  logic led1, stop_a_n, stop_b_n, pin4_out, pin4_oe;
  logic a_led1, a_stop_a_n, a_stop_b_n, a_pin4_out, a_pin4_oe;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  bit  armed = 0;

  always #2 clk = ~clk;

  ind_stop_ctrl #(.HALF_TICKS(HALF), .ALT_FLASH(1'b0)) i_ind_stop_ctrl (
    .clk(clk), .rst(rst), .stop_wr(stop_wr), .stop_din(stop_din),
    .mode_wr(mode_wr), .mode_din(mode_din), .tick(tick), .sect_led(sect_led),
    .led1(led1), .stop_a_n(stop_a_n), .stop_b_n(stop_b_n),
    .pin4_out(pin4_out), .pin4_oe(pin4_oe));

  ind_stop_ctrl #(.HALF_TICKS(HALF), .ALT_FLASH(1'b1)) i_ind_stop_ctrl_alt (
    .clk(clk), .rst(rst), .stop_wr(stop_wr), .stop_din(stop_din),
    .mode_wr(mode_wr), .mode_din(mode_din), .tick(tick), .sect_led(sect_led),
    .led1(a_led1), .stop_a_n(a_stop_a_n), .stop_b_n(a_stop_b_n),
    .pin4_out(a_pin4_out), .pin4_oe(a_pin4_oe));

  // behavioural reference model, stepped on every rising edge
  int m_stop, m_flash, m_p4led, m_p4trig, m_cnt, m_ph;
  bit e_led1, e_sa, e_sb, e_out, e_oe, e_aout;

  always @(posedge clk) begin
    if (rst) begin
      m_stop = 7; m_flash = 1; m_p4led = 1; m_p4trig = 1;
      m_cnt = 0; m_ph = 1;
      e_led1 = 0; e_sa = 0; e_sb = 0; e_out = 0; e_oe = 0; e_aout = 0;
      armed = 1;
    end else begin
      bit l2s, l2a;
      e_led1 = sect_led && (m_flash != 0 ? m_ph != 0 : 1'b1);
      l2s    = e_led1;
      l2a    = sect_led && (m_flash != 0 ? m_ph == 0 : 1'b1);
      e_sa   = (m_stop & 1) == 0;
      e_sb   = (m_stop & 2) == 0;
      e_oe   = (m_p4trig == 0);
      if (m_p4trig != 0) begin
        e_out = 0; e_aout = 0;
      end else if (m_p4led != 0) begin
        e_out = l2s; e_aout = l2a;
      end else begin
        e_out = (m_stop & 4) == 0; e_aout = e_out;
      end
      if (stop_wr) m_stop = stop_din & 7;
      if (mode_wr) begin
        m_flash = mode_din[7]; m_p4led = mode_din[6]; m_p4trig = mode_din[5];
      end
      if (!sect_led) begin
        m_cnt = 0; m_ph = 1;
      end else if (tick) begin
        if (m_cnt == HALF - 1) begin m_cnt = 0; m_ph = 1 - m_ph; end
        else m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (armed && !done) begin
      chk("R5 R6 R7 R8 led1", led1, e_led1);
      chk("R1 R2 stop_a_n", stop_a_n, e_sa);
      chk("R1 R2 stop_b_n", stop_b_n, e_sb);
      chk("R11 R12 pin4_oe", pin4_oe, e_oe);
      chk("R9 R12 pin4_out", pin4_out, e_out);
      chk("R10 alt pin4_out", a_pin4_out, e_aout);
      chk("R10 alt led1", a_led1, e_led1);
      chk("R11 alt pin4_oe", a_pin4_oe, e_oe);
    end
  end

  task automatic wr_stop(input logic [7:0] v);
    @(negedge clk); stop_wr = 1'b1; stop_din = v;
    @(negedge clk); stop_wr = 1'b0;
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_din = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    idle(3);
    // R3 reset state
    chk("R3 led1", led1, 1'b0);
    chk("R3 stop_a_n", stop_a_n, 1'b0);
    chk("R3 stop_b_n", stop_b_n, 1'b0);
    chk("R3 pin4_oe", pin4_oe, 1'b0);
    chk("R3 pin4_out", pin4_out, 1'b0);
    rst = 1'b0;
    idle(2);

    // R4 latency: written at edge k, old value after k, new after k+1
    @(negedge clk); stop_wr = 1'b1; stop_din = 8'h00;
    @(negedge clk); stop_wr = 1'b0;
    chk("R4 old value", stop_a_n, 1'b0);
    @(negedge clk);
    chk("R4 new value", stop_a_n, 1'b1);
    chk("R2 inactive high", stop_b_n, 1'b1);

    // R1 upper stop bits ignored
    wr_stop(8'hF8); idle(2);
    chk("R1 upper bits a", stop_a_n, 1'b1);
    chk("R1 upper bits b", stop_b_n, 1'b1);
    wr_stop(8'h05); idle(2);
    chk("R2 a low", stop_a_n, 1'b0);
    chk("R2 b high", stop_b_n, 1'b1);

    // R12 shared pin as third stop line
    wr_mode(8'h00); idle(2);
    chk("R12 stop role oe", pin4_oe, 1'b1);
    chk("R12 stop role low", pin4_out, 1'b0);
    wr_stop(8'h03); idle(2);
    chk("R12 stop role high", pin4_out, 1'b1);

    // R6 steady LEDs, shared pin as LED2
    wr_mode(8'h40);
    sect_led = 1'b1; tick = 1'b1;
    idle(12);
    chk("R6 steady led1", led1, 1'b1);
    chk("R9 led2 steady", pin4_out, 1'b1);
    chk("R6 alt steady", a_pin4_out, 1'b1);

    // R7 flash with tick every cycle, R8 restart
    wr_mode(8'hC0);
    idle(30);
    sect_led = 1'b0; idle(3);
    chk("R5 dark", led1, 1'b0);
    sect_led = 1'b1; @(negedge clk);
    chk("R8 lit start", led1, 1'b1);
    idle(20);
    tick = 1'b0;

    // R13 low mode bits ignored
    wr_mode(8'hDF); idle(4);
    wr_mode(8'h1F); idle(2);
    chk("R13 low bits oe", pin4_oe, 1'b1);
    chk("R11 R13 pin4 drives", pin4_oe, 1'b1);
    wr_mode(8'h20); idle(2);
    chk("R11 trigger oe", pin4_oe, 1'b0);
    chk("R11 trigger out", pin4_out, 1'b0);

    // mixed random stimulus
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick     = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 39) == 0) sect_led = ~sect_led;
      stop_wr  = ($urandom_range(0, 29) == 0);
      stop_din = 8'($urandom);
      mode_wr  = ($urandom_range(0, 29) == 0);
      mode_din = 8'($urandom);
    end
    @(negedge clk); stop_wr = 1'b0; mode_wr = 1'b0;
    idle(3);
    finish_run();
  end

endmodule